// File: doc/BRIEF.md
# Bit-Serial Two-Operand Adder

This block adds two WIDTH-bit unsigned numbers one bit per clock, starting with the least significant bit. Both operands sit in right-shift registers that can also be loaded in parallel. One full adder takes the low bit of each register and a stored carry. Each sum bit enters the top of the A register as A shifts right. A single flip-flop holds the carry from one bit-time to the next. After WIDTH shifts, the A register holds the sum and the carry flip-flop holds the carry out of the top bit.

A small controller has three states. IDLE waits for commands. RUN shifts once per cycle while a bit counter steps through the bit positions. FIN marks completion for one cycle. The transitions are:
- IDLE -> RUN when start is high and load is low.
- RUN -> RUN while the counter is below WIDTH-1.
- RUN -> FIN when the counter reaches WIDTH-1.
- FIN -> IDLE always.
- IDLE -> IDLE otherwise.

The carry is cleared only by a load. A second start with no load in between therefore uses the carry left by the previous pass as its carry-in, which lets results be chained. The serial input of the B register is either constant zero or an external bit stream, chosen by a select pin.

Top module: `serial_adder`

## Requirements
- R1: After reset the block is in IDLE. busy, done, sum_o and carry_o are all 0, and both operand registers hold 0.
- R2: A load in IDLE copies a_in into the A register and b_in into the B register, and clears the carry. From the next cycle, sum_o equals a_in and carry_o equals 0.
- R3: A start in IDLE with load low raises busy from the next cycle. busy then stays high for exactly WIDTH consecutive cycles.
- R4: done is high for exactly one cycle, the cycle right after the last busy cycle. In that cycle {carry_o, sum_o} equals A + B + carry-in, where carry-in is the carry flip-flop value when the pass started.
- R5: When load and start are both high in IDLE, only the load takes effect and no pass starts. load and start are ignored while busy or done is high: they do not change the result and do not lengthen the pass.
- R6: A start with no new load uses the carry left by the previous pass as carry-in, so sum_o becomes previous sum + B + previous carry.
- R7: When b_ser_sel is 0, zeros shift into the top of B, so B is 0 after a pass. When b_ser_sel is 1, B ends the pass holding the WIDTH bits presented on b_ser_in: the bit presented in the first busy cycle lands in bit 0, the bit presented in the last busy cycle lands in bit WIDTH-1.
- R8: Outside RUN, and with no accepted load, sum_o and carry_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Parallel load of both operands, accepted in IDLE |
| a_in | input | WIDTH | Parallel value for operand A |
| b_in | input | WIDTH | Parallel value for operand B |
| start | input | 1 | Begin a serial pass, accepted in IDLE when load is low |
| b_ser_sel | input | 1 | 1: B shifts in b_ser_in; 0: B shifts in zero |
| b_ser_in | input | 1 | External serial bit for the top of B |
| busy | output | 1 | High during the WIDTH shifting cycles |
| done | output | 1 | One-cycle completion marker |
| sum_o | output | WIDTH | Contents of the A register (the sum after a pass) |
| carry_o | output | 1 | Carry flip-flop |

## Verification
Some rules are checked by assertions on every cycle:
- busy and done are never high together.
- Every pass lasts exactly WIDTH busy cycles, and done is a single pulse that follows busy.
- An accepted load clears the carry and shows a_in.
- Outside RUN the result does not change.

The arithmetic can only be shown by the bench scenarios, which compare against a model: random and corner sums such as all ones plus one, the carry chained into a second pass, and the serial filling of B. The bench scenarios also show that a start sent together with a load, or during a pass, is ignored.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } bsa_state_e;
endpackage

// File: rtl/bsa_shreg.sv
module bsa_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             shift_en,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load_en) begin
            q <= par_in;
        end else if (shift_en) begin
            q <= {ser_in, q[WIDTH-1:1]};
        end
    end
endmodule

// File: rtl/bsa_fa_carry.sv
module bsa_fa_carry (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic a_bit,
    input  logic b_bit,
    output logic sum_bit,
    output logic carry_q
);
    logic cout;

    always_comb begin
        sum_bit = a_bit ^ b_bit ^ carry_q;
        cout    = (a_bit & b_bit) | (carry_q & (a_bit ^ b_bit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (clr) begin
            carry_q <= 1'b0;
        end else if (en) begin
            carry_q <= cout;
        end
    end
endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl
    import bsa_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_req,
    input  logic start_req,
    output logic load_en,
    output logic shift_en,
    output logic busy,
    output logic done
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    bsa_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_req && !load_req) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && cnt_q != LAST) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    always_comb begin
        load_en  = 1'b0;
        shift_en = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: load_en = load_req;
            ST_RUN: begin
                shift_en = 1'b1;
                busy     = 1'b1;
            end
            ST_FIN:  done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/serial_adder.sv
module serial_adder #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             start,
    input  logic             b_ser_sel,
    input  logic             b_ser_in,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o
);
    logic             load_en;
    logic             shift_en;
    logic             fa_sum;
    logic             b_fill;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;

    assign b_fill = b_ser_sel ? b_ser_in : 1'b0;

    bsa_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_req  (load),
        .start_req (start),
        .load_en   (load_en),
        .shift_en  (shift_en),
        .busy      (busy),
        .done      (done)
    );

    bsa_shreg #(.WIDTH(WIDTH)) u_areg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .shift_en (shift_en),
        .par_in   (a_in),
        .ser_in   (fa_sum),
        .q        (a_q)
    );

    bsa_shreg #(.WIDTH(WIDTH)) u_breg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .shift_en (shift_en),
        .par_in   (b_in),
        .ser_in   (b_fill),
        .q        (b_q)
    );

    bsa_fa_carry u_fa (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (load_en),
        .en      (shift_en),
        .a_bit   (a_q[0]),
        .b_bit   (b_q[0]),
        .sum_bit (fa_sum),
        .carry_q (carry_o)
    );

    assign sum_o = a_q;
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load,
    input logic [WIDTH-1:0] a_in,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] sum_o,
    input logic             carry_o
);
    int unsigned busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else busy_run <= 0;
    end

    a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done}));

    a_r4_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_start_needed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start) && !$past(load));

    a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_run == WIDTH);

    a_r5_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_run < WIDTH);

    a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy && !done) |=> (carry_o == 1'b0) && (sum_o == $past(a_in)));

    a_r8_hold_outside_run: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> $stable(sum_o) && $stable(carry_o));
endmodule

bind serial_adder bsa_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .a_in    (a_in),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .sum_o   (sum_o),
    .carry_o (carry_o)
);

// File: tb/serial_adder_tb.sv
module serial_adder_tb;
    localparam int W = 8;
    localparam time CLK_PERIOD = 10ns;
    localparam int WATCHDOG = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         start = 1'b0;
    logic         b_ser_sel = 1'b0;
    logic         b_ser_in = 1'b0;
    logic         busy, done, carry_o;
    logic [W-1:0] sum_o;

    int n_chk = 0;
    int n_bad = 0;
    logic         m_carry;
    logic [W-1:0] m_a, m_b;

    serial_adder #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .a_in(a_in), .b_in(b_in),
        .start(start), .b_ser_sel(b_ser_sel), .b_ser_in(b_ser_in),
        .busy(busy), .done(done), .sum_o(sum_o), .carry_o(carry_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W:0] add_model(logic [W-1:0] a, logic [W-1:0] b, logic c);
        return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    endfunction

    task automatic check(string req, logic [W+2:0] act, logic [W+2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_load(logic [W-1:0] a, logic [W-1:0] b);
        @(negedge clk);
        load = 1'b1; a_in = a; b_in = b;
        @(negedge clk);
        load = 1'b0;
        m_a = a; m_b = b; m_carry = 1'b0;
        check("R2", {2'b0, carry_o, sum_o}, {2'b0, 1'b0, a});
    endtask

    // One pass; if disturb, load/start toggle mid-pass and during FIN (R5)
    task automatic do_pass(logic sel, logic [W-1:0] bits, logic disturb);
        logic [W:0] exp;
        exp = add_model(m_a, m_b, m_carry);
        @(negedge clk);
        start = 1'b1; b_ser_sel = sel;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < W; k++) begin
            check("R3", {2'b0, busy, done, {(W-1){1'b0}}}, {2'b0, 1'b1, 1'b0, {(W-1){1'b0}}});
            b_ser_in = bits[k];
            if (disturb && k == 2) begin
                load = 1'b1; start = 1'b1; a_in = ~m_a; b_in = ~m_b;
            end else begin
                load = 1'b0; start = 1'b0;
            end
            @(negedge clk);
        end
        if (disturb) begin load = 1'b1; start = 1'b1; a_in = 8'h5A; end
        check("R4", {1'b0, busy, done, carry_o, sum_o}, {1'b0, 1'b0, 1'b1, exp});
        @(negedge clk);
        load = 1'b0; start = 1'b0;
        check("R4", {2'b0, done, busy, {(W-1){1'b0}}}, '0);
        if (disturb) check("R5", {2'b0, carry_o, sum_o}, {2'b0, exp});
        m_a = exp[W-1:0]; m_carry = exp[W];
        m_b = sel ? bits : '0;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [W-1:0] ra, rb, rs;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        check("R1", {busy, done, carry_o, sum_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {busy, done, carry_o, sum_o}, '0);

        // R2/R4 corner sums
        do_load(8'hFF, 8'h01); do_pass(1'b0, '0, 1'b0);
        do_load(8'hFF, 8'hFF); do_pass(1'b0, '0, 1'b0);
        do_load(8'h00, 8'h00); do_pass(1'b0, '0, 1'b0);
        do_load(8'h80, 8'h80); do_pass(1'b0, '0, 1'b0);

        // R6 chained carry, R7 zero fill: B is 0, so result = A + carry
        do_load(8'hF0, 8'h20); do_pass(1'b0, '0, 1'b0);
        do_pass(1'b0, '0, 1'b0);
        check("R6", {2'b0, carry_o, sum_o}, {3'b0, 8'h11});

        // R7 serial fill of B, then second pass uses it
        do_load(8'h10, 8'h03); do_pass(1'b1, 8'hC5, 1'b0);
        do_pass(1'b0, '0, 1'b0);
        check("R7", {2'b0, carry_o, sum_o}, {3'b0, 8'hD8});

        // R5 load with start at once: load only
        @(negedge clk);
        load = 1'b1; start = 1'b1; a_in = 8'h3C; b_in = 8'h0F;
        @(negedge clk);
        load = 1'b0; start = 1'b0;
        m_a = 8'h3C; m_b = 8'h0F; m_carry = 1'b0;
        check("R5", {1'b0, busy, carry_o, sum_o}, {3'b0, 8'h3C});
        @(negedge clk);
        check("R5", {1'b0, busy, done, sum_o}, {3'b0, 8'h3C});
        // R5 disturbance during pass and FIN
        do_pass(1'b0, '0, 1'b1);

        // R8 idle hold
        repeat (3) @(negedge clk);
        check("R8", {2'b0, carry_o, sum_o}, {2'b0, m_carry, m_a});

        // random
        for (int i = 0; i < 40; i++) begin
            ra = W'($urandom); rb = W'($urandom); rs = W'($urandom);
            do_load(ra, rb);
            do_pass(rs[0], rs, 1'b0);
            if (i % 4 == 0) do_pass(1'b0, '0, 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule